// File: doc/BRIEF.md
# Masked Priority Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt sources and reduces them to a single 4-bit level code for a processor. Every source owns one bit of a 16-bit status word; the bit positions are fixed and deliberately scattered. A source is pending when its status bit and the matching bit of a software-written enable mask are both set. Among the pending sources, the one with the smallest level number wins. The winning number is XORed with 15 before it leaves the block, so an idle block drives 0 and the most urgent source drives 15.

The block also decodes a 64-byte window of 16-bit registers on a plain strobe bus with word addresses. The window holds the enable mask, a general-purpose output port, a constant version word, and a power-off control that produces a one-cycle shutdown request. Read data comes back one cycle after the strobe.

Top module: `intlvl_top`

## Requirements
- R1: After reset, the level output, the output port, the shutdown request and the enable mask are all zero.
- R2: The source with level number k sets status bit B(k), with B = 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 for k = 0..12. A source high with its mask bit clear is never pending.
- R3: The level output is 15 XOR (smallest pending level number). It is 0 when nothing is pending, so the values 1 and 2 never appear.
- R4: The level output reflects a change in a source or in the mask exactly one clock edge later.
- R5: The enable mask at word address 0 (byte 0x00) can be read and written. Accesses to other addresses leave it unchanged.
- R6: The output port register at word address 27 (byte 0x36) can be read and written, and its value drives the gpo output. Accesses to other addresses leave it unchanged.
- R7: Word address 25 (byte 0x32) reads 0x0010, and writes to it are ignored.
- R8: Word address 24 (byte 0x30) reads 0. A write there with bit 0 set raises shutdown_req for exactly one cycle, one edge after the write. A write with bit 0 clear raises nothing.
- R9: Reads of any other word address return 0, and writes to them change no register.
- R10: Read data appears on bus_rdata one clock edge after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 13 | Interrupt sources, bit k is the source with level number k |
| bus_vld | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address within the 64-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| gpo | output | 16 | Output port register value |
| shutdown_req | output | 1 | One-cycle shutdown request |
| int_lvl | output | 4 | Encoded interrupt level, 0 when idle |

## Verification
The encoder is driven with each source alone, with all sources together, and with scattered pairs. These patterns separate a wrong bit placement from a wrong priority order. A run with every source high and a single mask bit set confirms each source's mask position on its own. Removing the winning sources from the mask shows that the next-smallest level takes over. Toggling a source just before an edge shows the one-edge latency. For the register window, writes to the version, power-off and unmapped words are each followed by reads of the mask and the port, which shows that nothing stray was written.

// File: rtl/intlvl_pkg.sv
package intlvl_pkg;
  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int LVL_W   = 4;
  localparam int ADDR_W  = 5;

  localparam logic [LVL_W-1:0]  IDLE_SEL = '1;
  localparam logic [DATA_W-1:0] VER_WORD = 16'h0010;

  localparam logic [ADDR_W-1:0] WA_MASK = 5'd0;
  localparam logic [ADDR_W-1:0] WA_PWR  = 5'd24;
  localparam logic [ADDR_W-1:0] WA_VER  = 5'd25;
  localparam logic [ADDR_W-1:0] WA_GPO  = 5'd27;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_PWR, SEL_VER, SEL_GPO
  } reg_sel_e;

  // status-word bit owned by the source with level number lvl
  function automatic int unsigned stat_pos(input int unsigned lvl);
    case (lvl)
      0:  stat_pos = 11;
      1:  stat_pos = 9;
      2:  stat_pos = 8;
      3:  stat_pos = 12;
      4:  stat_pos = 10;
      5:  stat_pos = 6;
      6:  stat_pos = 5;
      7:  stat_pos = 4;
      8:  stat_pos = 7;
      9:  stat_pos = 14;
      10: stat_pos = 13;
      11: stat_pos = 0;
      12: stat_pos = 15;
      default: stat_pos = 1;
    endcase
  endfunction
endpackage

// File: rtl/intlvl_remap.sv
module intlvl_remap
  import intlvl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W
) (
  input  logic [N_SRC-1:0] src_lvl,
  output logic [DW-1:0]    stat_word
);
  always_comb begin
    stat_word = '0;
    for (int k = 0; k < N_SRC; k++) begin
      stat_word[stat_pos(k)] = src_lvl[k];
    end
  end
endmodule

// File: rtl/intlvl_select.sv
module intlvl_select
  import intlvl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W,
  parameter int LW    = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] stat_word,
  input  logic [DW-1:0] mask_nxt,
  output logic [LW-1:0] lvl_q
);
  logic [DW-1:0] pend;
  logic [LW-1:0] win;
  logic [LW-1:0] lvl_d;

  assign pend = stat_word & mask_nxt;

  // scan from the highest level down so the smallest pending number remains
  always_comb begin
    win = IDLE_SEL;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (pend[stat_pos(k)]) win = LW'(k);
    end
    lvl_d = win ^ IDLE_SEL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/intlvl_regs.sv
module intlvl_regs
  import intlvl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_vld,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] mask_nxt,
  output logic [DW-1:0] gpo_q,
  output logic [DW-1:0] rdata_q,
  output logic          shut_q
);
  reg_sel_e      sel;
  logic          wr_stb;
  logic          rd_stb;
  logic          mask_en;
  logic          gpo_en;
  logic [DW-1:0] gpo_d;
  logic [DW-1:0] rdata_d;
  logic          shut_d;

  always_comb begin
    case (bus_addr)
      WA_MASK: sel = SEL_MASK;
      WA_PWR:  sel = SEL_PWR;
      WA_VER:  sel = SEL_VER;
      WA_GPO:  sel = SEL_GPO;
      default: sel = SEL_NONE;
    endcase
  end

  assign wr_stb  = bus_vld & bus_we;
  assign rd_stb  = bus_vld & ~bus_we;
  assign mask_en = wr_stb & (sel == SEL_MASK);
  assign gpo_en  = wr_stb & (sel == SEL_GPO);

  always_comb begin
    mask_nxt = mask_en ? bus_wdata : mask_q;
    gpo_d    = gpo_en ? bus_wdata : gpo_q;
    shut_d   = wr_stb & (sel == SEL_PWR) & bus_wdata[0];
    case (sel)
      SEL_MASK: rdata_d = mask_q;
      SEL_GPO:  rdata_d = gpo_q;
      SEL_VER:  rdata_d = VER_WORD;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gpo_q  <= '0;
      shut_q <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_nxt;
      if (gpo_en)  gpo_q  <= gpo_d;
      shut_q <= shut_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rdata_d;
  end
endmodule

// File: rtl/intlvl_top.sv
module intlvl_top
  import intlvl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             bus_vld,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [DW-1:0]    gpo,
  output logic             shutdown_req,
  output logic [LW-1:0]    int_lvl
);
  logic [DW-1:0] stat_word;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] mask_nxt;

  intlvl_remap #(.N_SRC(N_SRC), .DW(DW)) u_remap (
    .src_lvl   (src_lvl),
    .stat_word (stat_word)
  );

  intlvl_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_vld   (bus_vld),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_q    (mask_q),
    .mask_nxt  (mask_nxt),
    .gpo_q     (gpo),
    .rdata_q   (bus_rdata),
    .shut_q    (shutdown_req)
  );

  intlvl_select #(.N_SRC(N_SRC), .DW(DW), .LW(LW)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_word (stat_word),
    .mask_nxt  (mask_nxt),
    .lvl_q     (int_lvl)
  );
endmodule

// File: rtl/intlvl_chk.sv
module intlvl_chk
  import intlvl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LVL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_lvl,
  input logic             bus_vld,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [DW-1:0]    gpo,
  input logic             shutdown_req,
  input logic [LW-1:0]    int_lvl,
  input logic [DW-1:0]    mask_q
);
  logic rd_any, wr_any, unlisted;
  assign rd_any   = bus_vld & ~bus_we;
  assign wr_any   = bus_vld & bus_we;
  assign unlisted = (bus_addr != WA_MASK) && (bus_addr != WA_PWR) &&
                    (bus_addr != WA_VER) && (bus_addr != WA_GPO);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl == '0) |=> (int_lvl == '0)); // R3

  AST_NO_LOW_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (int_lvl != LW'(1)) && (int_lvl != LW'(2))); // R3

  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl[0] && mask_q[11] && !(wr_any && bus_addr == WA_MASK))
    |=> (int_lvl == '1)); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && bus_addr == WA_MASK) |=> $stable(mask_q)); // R5

  AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && bus_addr == WA_GPO) |=> $stable(gpo)); // R6

  AST_VER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_addr == WA_VER) |=> (bus_rdata == VER_WORD)); // R7

  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_any && bus_addr == WA_PWR && bus_wdata[0])); // R8

  AST_PWR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_addr == WA_PWR) |=> (bus_rdata == '0)); // R8

  AST_UNLISTED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && unlisted) |=> (bus_rdata == '0)); // R9
endmodule

bind intlvl_top intlvl_chk #(.N_SRC(N_SRC), .DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_lvl      (src_lvl),
  .bus_vld      (bus_vld),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .gpo          (gpo),
  .shutdown_req (shutdown_req),
  .int_lvl      (int_lvl),
  .mask_q       (mask_q)
);

// File: tb/sim_intlvl_top.sv
`timescale 1ns/1ps
module sim_intlvl_top;
  logic        clk;
  logic        rst_n;
  logic [12:0] src_lvl;
  logic        bus_vld;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] gpo;
  logic        shutdown_req;
  logic [3:0]  int_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  intlvl_top u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpo(gpo),
    .shutdown_req(shutdown_req), .int_lvl(int_lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // status bit per level, from R2
  function automatic int bpos(input int k);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[k];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_we = 1'b0;
  endtask

  // driver: push the expected read value; monitor compares
  task automatic bus_rd(input logic [4:0] a, input logic [15:0] e, input string req);
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    bus_vld = 1'b0;
  endtask

  task automatic set_src(input logic [12:0] v, input logic [3:0] e, input string req);
    @(negedge clk);
    src_lvl = v;
    @(negedge clk);
    check(req, {12'h0, int_lvl}, {12'h0, e});
  endtask

  // monitor: read data one edge after the strobe (R10)
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_vld && !bus_we) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R10 unexpected read", bus_rdata, 16'h0);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] all;
    all = '1;
    rst_n = 1'b0; src_lvl = '0; bus_vld = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 int_lvl", {12'h0, int_lvl}, 16'h0);
    check("R1 gpo", gpo, 16'h0);
    check("R1 shutdown", {15'h0, shutdown_req}, 16'h0);
    bus_rd(5'd0, 16'h0000, "R1 mask");

    // masked source stays silent, mask write activates it (R2, R4, R5)
    set_src(13'h0001, 4'd0, "R2 masked source");
    bus_wr(5'd0, 16'h0800);
    check("R4 mask write latency", {12'h0, int_lvl}, 16'h000F);
    bus_rd(5'd0, 16'h0800, "R5 mask readback");

    // each source alone with full mask (R3)
    bus_wr(5'd0, 16'hFFFF);
    for (int k = 0; k < 13; k++) begin
      set_src(13'(1) << k, 4'(k) ^ 4'hF, "R3 single source");
    end
    set_src('0, 4'd0, "R3 idle");

    // all high, mask a single status bit at a time (R2)
    @(negedge clk); src_lvl = all;
    for (int k = 0; k < 13; k++) begin
      bus_wr(5'd0, 16'(1) << bpos(k));
      check("R2 mask position", {12'h0, int_lvl}, {12'h0, 4'(k) ^ 4'hF});
    end

    // lowest number wins (R3)
    bus_wr(5'd0, 16'hFFFF);
    set_src(all, 4'd15, "R3 all high");
    set_src((13'(1) << 12) | (13'(1) << 3), 4'd12, "R3 levels 3 and 12");
    set_src((13'(1) << 11) | (13'(1) << 8), 4'd7, "R3 levels 8 and 11");
    @(negedge clk); src_lvl = all;
    bus_wr(5'd0, 16'hFFFF & ~(16'(1) << 11) & ~(16'(1) << 9));
    check("R3 next winner", {12'h0, int_lvl}, 16'h000D);

    // one-edge latency (R4)
    bus_wr(5'd0, 16'hFFFF);
    @(negedge clk); src_lvl = 13'h0010;
    @(negedge clk);
    src_lvl = 13'h0002;
    #1 check("R4 before edge", {12'h0, int_lvl}, 16'h000B);
    @(negedge clk);
    check("R4 after edge", {12'h0, int_lvl}, 16'h000E);

    // output port (R6)
    bus_wr(5'd27, 16'hA5C3);
    check("R6 gpo pins", gpo, 16'hA5C3);
    bus_rd(5'd27, 16'hA5C3, "R6 gpo readback");

    // version (R7)
    bus_rd(5'd25, 16'h0010, "R7 version");
    bus_wr(5'd25, 16'hFFFF);
    bus_rd(5'd25, 16'h0010, "R7 version after write");

    // power-off (R8)
    bus_rd(5'd24, 16'h0000, "R8 power read");
    bus_wr(5'd24, 16'h0001);
    check("R8 pulse", {15'h0, shutdown_req}, 16'h1);
    @(negedge clk);
    check("R8 pulse ends", {15'h0, shutdown_req}, 16'h0);
    bus_wr(5'd24, 16'hFFFE);
    check("R8 bit0 clear", {15'h0, shutdown_req}, 16'h0);

    // unlisted addresses (R9), then confirm no stray write (R5, R6)
    bus_wr(5'd1, 16'h1234);
    bus_wr(5'd5, 16'h5678);
    bus_wr(5'd31, 16'h9ABC);
    bus_wr(5'd26, 16'hDEF0);
    bus_rd(5'd1, 16'h0000, "R9 read 1");
    bus_rd(5'd31, 16'h0000, "R9 read 31");
    bus_rd(5'd26, 16'h0000, "R9 read 26");
    bus_rd(5'd0, 16'hFFFF, "R5 mask untouched");
    bus_rd(5'd27, 16'hA5C3, "R6 gpo untouched");
    check("R9 gpo pins", gpo, 16'hA5C3);

    repeat (3) @(negedge clk);
    check("R10 queue drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule